// File: doc/BRIEF.md
# Memory Error Telemetry and Page Retirement

This block receives error reports from a memory-protection decoder and uses them to decide when physical memory pages must stop being used. It takes two report streams, one for on-chip SRAM and one for off-chip DRAM. Each report is a valid strobe, a severity bit (1 = uncorrectable, 0 = corrected) and a physical address. The block keeps two sets of four saturating counters. The volatile set is cleared by the device reset input `devReset`. The persistent set survives `devReset` and is loaded and saved by an external controller through a restore port and a save port.

DRAM pages are 4 KB. A page is retired after one uncorrectable DRAM error, or after repeated corrected errors on that page. Repeated corrected errors are tracked in a small page-hit table that evicts the least recently used entry. A new retirement stays pending until the next `devReset` commits it. A replace-device flag is raised on any uncorrectable SRAM error, or when the number of retired pages passes a limit. A rate alarm fires when corrected errors in one monitoring window pass a threshold. An interrupt pulse is raised on every uncorrectable error. Software reads counters, retirement totals and the last faulting address through a combinational read port indexed by `regAddr`.

Top module: `memErrTelemetry`

## Requirements
- R1: Each event increments exactly one volatile counter, selected by class and severity. The read indices are 0 for SRAM corrected, 1 for SRAM uncorrectable, 2 for DRAM corrected and 3 for DRAM uncorrectable. An SRAM event and a DRAM event in the same cycle are both counted.
- R2: The persistent counters at read indices 4 to 7, in the same class order, count the same events and keep their values across `devReset`. While `restoreValid` is high they load from `restoreData`, with counter k taken from bits [16k+15:16k]. `saveData` always shows them in that same packing.
- R3: `devReset` clears volatile counters 0 to 3.
- R4: Every event counter saturates at all ones and never wraps.
- R5: An uncorrectable DRAM event retires page addr[31:12]. Read index 9 counts retirements caused by uncorrectable errors, and read index 11 holds the total number of retired pages.
- R6: The second corrected DRAM error on a page that is still held in the 4-entry page-hit table retires that page. Read index 8 counts these retirements. The table evicts its least recently used page, and a page that has been evicted starts again from one hit.
- R7: An event whose page is already retired (pending or committed) updates the counters but creates no new retirement.
- R8: `retirePending` is high from the cycle after any retirement until a `devReset` cycle commits all pending entries.
- R9: `replaceDevice` rises in the cycle after an uncorrectable SRAM event, or in the cycle after the total number of retired pages exceeds 64. It stays high until `porN`.
- R10: `rateAlarm` is a one-cycle pulse that fires when the number of corrected events (both classes) in the current window exceeds 100. A window ends after `windowTicks` pulses of `timerTick`, and `devReset` restarts it.
- R11: `uncorrIrq` pulses for one cycle after each cycle that holds an uncorrectable event. Read index 10 latches the faulting address, and the DRAM address wins when both streams report an uncorrectable error in the same cycle.
- R12: After `porN`, every read index returns zero and all output flags are low. Only `porN` clears the retirement table, the retirement counts and the latched fault address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| devReset | input | 1 | Synchronous device reset: clears volatile state and commits pending retirements |
| sramEvtValid | input | 1 | SRAM error report valid |
| sramEvtUncorr | input | 1 | SRAM report severity, 1 = uncorrectable |
| sramEvtAddr | input | 32 | SRAM faulting address |
| dramEvtValid | input | 1 | DRAM error report valid |
| dramEvtUncorr | input | 1 | DRAM report severity, 1 = uncorrectable |
| dramEvtAddr | input | 32 | DRAM faulting physical address |
| timerTick | input | 1 | Monitoring timer tick |
| windowTicks | input | 16 | Window length in ticks |
| restoreValid | input | 1 | Load the persistent counters |
| restoreData | input | 64 | Persistent counter values to load |
| saveData | output | 64 | Current persistent counter values |
| regAddr | input | 4 | Read index |
| regRdData | output | 32 | Read data |
| uncorrIrq | output | 1 | Uncorrectable-error interrupt pulse |
| rateAlarm | output | 1 | Corrected-error rate alarm pulse |
| retirePending | output | 1 | At least one retirement awaits commit |
| replaceDevice | output | 1 | Device replacement condition |

## Verification
An uncorrectable SRAM report and an uncorrectable DRAM report can arrive in the same cycle. Both counters must then advance, the interrupt must fire once, and the latched address and the retirement must come from the DRAM report. The bench drives both streams on one edge. It then reads indices 1, 3, 5, 7 and 10 and checks the interrupt and the replace flag in the following cycle. A second simultaneous case is a corrected DRAM error on a page that is already retired, paired with the rate window. It is judged through indices 2 and 11: the corrected count rises while the retirement total stays the same.

// File: rtl/memErrPkg.sv
package memErrPkg;

  // counter slot order, shared by the read map and the save/restore packing
  typedef enum logic [1:0] {
    SLOT_SRAM_CE = 2'd0,
    SLOT_SRAM_UE = 2'd1,
    SLOT_DRAM_CE = 2'd2,
    SLOT_DRAM_UE = 2'd3
  } errSlotE;

  localparam int SLOT_N = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic [SLOT_N-1:0] bump;      // one per counter slot
    logic              latchDram; // capture DRAM address as fault address
    logic              latchSram; // capture SRAM address as fault address
    logic              clrVol;    // clear volatile counters
  } strobeT;

  // read indices beyond the counters
  localparam logic [3:0] RD_RET_CE    = 4'd8;
  localparam logic [3:0] RD_RET_UE    = 4'd9;
  localparam logic [3:0] RD_FAULT     = 4'd10;
  localparam logic [3:0] RD_RET_TOTAL = 4'd11;

endpackage

// File: rtl/memErrCtrl.sv
module memErrCtrl
  import memErrPkg::*;
#(
  parameter int WIN_W        = 16,
  parameter int RATE_LIMIT   = 100,
  parameter int RETIRE_LIMIT = 64,
  parameter int RIDX_W       = 7
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              devReset,
  input  logic              sramEvtValid,
  input  logic              sramEvtUncorr,
  input  logic              dramEvtValid,
  input  logic              dramEvtUncorr,
  input  logic              timerTick,
  input  logic [WIN_W-1:0]  windowTicks,
  input  logic [RIDX_W-1:0] retTotal,
  output strobeT            strobe,
  output logic              uncorrIrq,
  output logic              rateAlarm,
  output logic              replaceDevice
);

  localparam int RC_W = $clog2(RATE_LIMIT + 4);
  localparam logic [RC_W-1:0] LIM = RC_W'(RATE_LIMIT);

  logic [WIN_W-1:0] tickCnt;
  logic [RC_W-1:0]  winCnt;
  logic [RC_W-1:0]  corrInc, base, sum, winNext;
  logic             roll, alarmNext;

  always_comb begin
    strobe                           = '0;
    strobe.bump[int'(SLOT_SRAM_CE)]  = sramEvtValid && !sramEvtUncorr;
    strobe.bump[int'(SLOT_SRAM_UE)]  = sramEvtValid &&  sramEvtUncorr;
    strobe.bump[int'(SLOT_DRAM_CE)]  = dramEvtValid && !dramEvtUncorr;
    strobe.bump[int'(SLOT_DRAM_UE)]  = dramEvtValid &&  dramEvtUncorr;
    strobe.latchDram                 = dramEvtValid &&  dramEvtUncorr;
    strobe.latchSram                 = sramEvtValid &&  sramEvtUncorr && !strobe.latchDram;
    strobe.clrVol                    = devReset;
  end

  // window accounting: events in a rolling cycle count toward the new window
  always_comb begin
    roll      = timerTick && (({1'b0, tickCnt} + 1'b1) >= {1'b0, windowTicks});
    corrInc   = RC_W'(strobe.bump[int'(SLOT_SRAM_CE)]) + RC_W'(strobe.bump[int'(SLOT_DRAM_CE)]);
    base      = roll ? '0 : winCnt;
    sum       = base + corrInc;
    alarmNext = (sum > LIM) && (base <= LIM);
    winNext   = (sum > LIM) ? (LIM + 1'b1) : sum;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      tickCnt       <= '0;
      winCnt        <= '0;
      rateAlarm     <= 1'b0;
      uncorrIrq     <= 1'b0;
      replaceDevice <= 1'b0;
    end else begin
      uncorrIrq     <= strobe.bump[int'(SLOT_SRAM_UE)] | strobe.bump[int'(SLOT_DRAM_UE)];
      replaceDevice <= replaceDevice | strobe.bump[int'(SLOT_SRAM_UE)]
                       | (retTotal > RIDX_W'(RETIRE_LIMIT));
      if (devReset) begin
        tickCnt   <= '0;
        winCnt    <= '0;
        rateAlarm <= 1'b0;
      end else begin
        if (roll)           tickCnt <= '0;
        else if (timerTick) tickCnt <= tickCnt + 1'b1;
        winCnt    <= winNext;
        rateAlarm <= alarmNext;
      end
    end
  end

  // R9
  replace_sticky_chk: assert property (@(posedge clk) disable iff (!porN)
    replaceDevice |=> replaceDevice);

  // R10
  alarm_pulse_chk: assert property (@(posedge clk) disable iff (!porN)
    rateAlarm |=> !rateAlarm);

endmodule

// File: rtl/memErrRetire.sv
module memErrRetire #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int RET_DEPTH  = 72,
  parameter int HIT_DEPTH  = 4,
  parameter int HIT_THRESH = 2,
  parameter int CNT_W      = 16,
  parameter int RIDX_W     = 7
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              devReset,
  input  logic              dramEvtValid,
  input  logic              dramEvtUncorr,
  input  logic [ADDR_W-1:0] dramEvtAddr,
  output logic [CNT_W-1:0]  retCeCnt,
  output logic [CNT_W-1:0]  retUeCnt,
  output logic [RIDX_W-1:0] retTotal,
  output logic              retirePending
);

  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int HC_W   = $clog2(HIT_THRESH + 1);
  localparam int HI_W   = (HIT_DEPTH > 1) ? $clog2(HIT_DEPTH) : 1;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [PAGE_W-1:0] retPage [RET_DEPTH];
  logic [RET_DEPTH-1:0] retV, retPend;

  logic [PAGE_W-1:0] hitPage [HIT_DEPTH];
  logic [HC_W-1:0]   hitCnt  [HIT_DEPTH];
  logic [HIT_DEPTH-1:0] hitV;
  logic [PAGE_W-1:0] nP [HIT_DEPTH];
  logic [HC_W-1:0]   nC [HIT_DEPTH];
  logic [HIT_DEPTH-1:0] nV;

  logic [PAGE_W-1:0] page;
  logic              alreadyRetired, hitFound, room;
  logic [HI_W-1:0]   hitIdx;
  logic [HC_W-1:0]   hitCntInc;
  logic              ueEvt, ceEvt, crossing, doRetire;

  assign page = dramEvtAddr[ADDR_W-1:PAGE_SHIFT];

  always_comb begin
    alreadyRetired = 1'b0;
    for (int i = 0; i < RET_DEPTH; i++)
      if (retV[i] && retPage[i] == page) alreadyRetired = 1'b1;
    hitFound = 1'b0;
    hitIdx   = '0;
    for (int j = 0; j < HIT_DEPTH; j++)
      if (hitV[j] && hitPage[j] == page) begin
        hitFound = 1'b1;
        hitIdx   = HI_W'(j);
      end
  end

  always_comb begin
    room      = retTotal < RIDX_W'(RET_DEPTH);
    ueEvt     = dramEvtValid &&  dramEvtUncorr && !alreadyRetired;
    ceEvt     = dramEvtValid && !dramEvtUncorr && !alreadyRetired;
    hitCntInc = hitCnt[hitIdx] + 1'b1;
    crossing  = ceEvt && hitFound && (hitCntInc >= HC_W'(HIT_THRESH));
    doRetire  = room && (ueEvt || crossing);
  end

  // page-hit table kept in recency order, most recent at slot 0
  always_comb begin
    for (int j = 0; j < HIT_DEPTH; j++) begin
      nV[j] = hitV[j];
      nP[j] = hitPage[j];
      nC[j] = hitCnt[j];
    end
    if (ceEvt) begin
      if (crossing) begin
        for (int j = 0; j < HIT_DEPTH - 1; j++)
          if (j >= int'(hitIdx)) begin
            nV[j] = hitV[j+1];
            nP[j] = hitPage[j+1];
            nC[j] = hitCnt[j+1];
          end
        nV[HIT_DEPTH-1] = 1'b0;
      end else begin
        for (int j = 1; j < HIT_DEPTH; j++)
          if (!hitFound || j <= int'(hitIdx)) begin
            nV[j] = hitV[j-1];
            nP[j] = hitPage[j-1];
            nC[j] = hitCnt[j-1];
          end
        nV[0] = 1'b1;
        nP[0] = page;
        nC[0] = hitFound ? hitCntInc : HC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      hitV <= '0;
      for (int j = 0; j < HIT_DEPTH; j++) begin
        hitPage[j] <= '0;
        hitCnt[j]  <= '0;
      end
    end else begin
      hitV <= nV;
      for (int j = 0; j < HIT_DEPTH; j++) begin
        hitPage[j] <= nP[j];
        hitCnt[j]  <= nC[j];
      end
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      retV     <= '0;
      retPend  <= '0;
      retTotal <= '0;
      retCeCnt <= '0;
      retUeCnt <= '0;
      for (int i = 0; i < RET_DEPTH; i++) retPage[i] <= '0;
    end else begin
      for (int i = 0; i < RET_DEPTH; i++) begin
        if (doRetire && retTotal == RIDX_W'(i)) begin
          retV[i]    <= 1'b1;
          retPend[i] <= 1'b1;
          retPage[i] <= page;
        end else if (devReset) begin
          retPend[i] <= 1'b0;
        end
      end
      if (doRetire) retTotal <= retTotal + 1'b1;
      if (doRetire && crossing && retCeCnt != CMAX) retCeCnt <= retCeCnt + 1'b1;
      if (doRetire && ueEvt    && retUeCnt != CMAX) retUeCnt <= retUeCnt + 1'b1;
    end
  end

  assign retirePending = |retPend;

  // R7
  dup_retire_chk: assert property (@(posedge clk) disable iff (!porN)
    (dramEvtValid && alreadyRetired) |=> (retTotal == $past(retTotal)));

  // R8
  commit_clear_chk: assert property (@(posedge clk) disable iff (!porN)
    (devReset && !doRetire) |=> !retirePending);

  // R8
  pend_occupied_chk: assert property (@(posedge clk) disable iff (!porN)
    retirePending |-> (retTotal != '0));

endmodule

// File: rtl/memErrDatapath.sv
module memErrDatapath
  import memErrPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32,
  parameter int RIDX_W = 7
) (
  input  logic                  clk,
  input  logic                  porN,
  input  strobeT                strobe,
  input  logic [ADDR_W-1:0]     sramEvtAddr,
  input  logic [ADDR_W-1:0]     dramEvtAddr,
  input  logic                  restoreValid,
  input  logic [SLOT_N*CNT_W-1:0] restoreData,
  output logic [SLOT_N*CNT_W-1:0] saveData,
  input  logic [CNT_W-1:0]      retCeCnt,
  input  logic [CNT_W-1:0]      retUeCnt,
  input  logic [RIDX_W-1:0]     retTotal,
  input  logic [3:0]            regAddr,
  output logic [REG_W-1:0]      regRdData
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0]  volCnt  [SLOT_N];
  logic [CNT_W-1:0]  persCnt [SLOT_N];
  logic [ADDR_W-1:0] faultAddr;

  for (genvar g = 0; g < SLOT_N; g++) begin : gSlot
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)                                    volCnt[g] <= '0;
      else if (strobe.clrVol)                       volCnt[g] <= '0;
      else if (strobe.bump[g] && volCnt[g] != CMAX) volCnt[g] <= volCnt[g] + 1'b1;
    end

    always_ff @(posedge clk or negedge porN) begin
      if (!porN)                                     persCnt[g] <= '0;
      else if (restoreValid)                         persCnt[g] <= restoreData[g*CNT_W +: CNT_W];
      else if (strobe.bump[g] && persCnt[g] != CMAX) persCnt[g] <= persCnt[g] + 1'b1;
    end

    assign saveData[g*CNT_W +: CNT_W] = persCnt[g];

    // R1 R4
    vol_no_wrap_chk: assert property (@(posedge clk) disable iff (!porN)
      !strobe.clrVol |=> (volCnt[g] >= $past(volCnt[g])));
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                 faultAddr <= '0;
    else if (strobe.latchDram) faultAddr <= dramEvtAddr;
    else if (strobe.latchSram) faultAddr <= sramEvtAddr;
  end

  always_comb begin
    if (regAddr[3:2] == 2'b00)      regRdData = REG_W'(volCnt[regAddr[1:0]]);
    else if (regAddr[3:2] == 2'b01) regRdData = REG_W'(persCnt[regAddr[1:0]]);
    else begin
      case (regAddr)
        RD_RET_CE:    regRdData = REG_W'(retCeCnt);
        RD_RET_UE:    regRdData = REG_W'(retUeCnt);
        RD_FAULT:     regRdData = REG_W'(faultAddr);
        RD_RET_TOTAL: regRdData = REG_W'(retTotal);
        default:      regRdData = '0;
      endcase
    end
  end

  // R2
  save_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    (!restoreValid && strobe.bump == '0) |=> $stable(saveData));

endmodule

// File: rtl/memErrTelemetry.sv
module memErrTelemetry
  import memErrPkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int CNT_W        = 16,
  parameter int REG_W        = 32,
  parameter int PAGE_SHIFT   = 12,
  parameter int RET_DEPTH    = 72,
  parameter int RETIRE_LIMIT = 64,
  parameter int HIT_DEPTH    = 4,
  parameter int HIT_THRESH   = 2,
  parameter int RATE_LIMIT   = 100,
  parameter int WIN_W        = 16
) (
  input  logic                    clk,
  input  logic                    porN,
  input  logic                    devReset,
  input  logic                    sramEvtValid,
  input  logic                    sramEvtUncorr,
  input  logic [ADDR_W-1:0]       sramEvtAddr,
  input  logic                    dramEvtValid,
  input  logic                    dramEvtUncorr,
  input  logic [ADDR_W-1:0]       dramEvtAddr,
  input  logic                    timerTick,
  input  logic [WIN_W-1:0]        windowTicks,
  input  logic                    restoreValid,
  input  logic [4*CNT_W-1:0]      restoreData,
  output logic [4*CNT_W-1:0]      saveData,
  input  logic [3:0]              regAddr,
  output logic [REG_W-1:0]        regRdData,
  output logic                    uncorrIrq,
  output logic                    rateAlarm,
  output logic                    retirePending,
  output logic                    replaceDevice
);

  localparam int RIDX_W = $clog2(RET_DEPTH + 1);

  strobeT             strobe;
  logic [CNT_W-1:0]   retCeCnt, retUeCnt;
  logic [RIDX_W-1:0]  retTotal;

  memErrCtrl #(
    .WIN_W(WIN_W), .RATE_LIMIT(RATE_LIMIT),
    .RETIRE_LIMIT(RETIRE_LIMIT), .RIDX_W(RIDX_W)
  ) i_ctrl (
    .clk(clk), .porN(porN), .devReset(devReset),
    .sramEvtValid(sramEvtValid), .sramEvtUncorr(sramEvtUncorr),
    .dramEvtValid(dramEvtValid), .dramEvtUncorr(dramEvtUncorr),
    .timerTick(timerTick), .windowTicks(windowTicks), .retTotal(retTotal),
    .strobe(strobe), .uncorrIrq(uncorrIrq), .rateAlarm(rateAlarm),
    .replaceDevice(replaceDevice)
  );

  memErrRetire #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .RET_DEPTH(RET_DEPTH),
    .HIT_DEPTH(HIT_DEPTH), .HIT_THRESH(HIT_THRESH), .CNT_W(CNT_W), .RIDX_W(RIDX_W)
  ) i_retire (
    .clk(clk), .porN(porN), .devReset(devReset),
    .dramEvtValid(dramEvtValid), .dramEvtUncorr(dramEvtUncorr), .dramEvtAddr(dramEvtAddr),
    .retCeCnt(retCeCnt), .retUeCnt(retUeCnt), .retTotal(retTotal),
    .retirePending(retirePending)
  );

  memErrDatapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W), .RIDX_W(RIDX_W)
  ) i_datapath (
    .clk(clk), .porN(porN), .strobe(strobe),
    .sramEvtAddr(sramEvtAddr), .dramEvtAddr(dramEvtAddr),
    .restoreValid(restoreValid), .restoreData(restoreData), .saveData(saveData),
    .retCeCnt(retCeCnt), .retUeCnt(retUeCnt), .retTotal(retTotal),
    .regAddr(regAddr), .regRdData(regRdData)
  );

endmodule

// File: tb/test_memErrTelemetry.sv
module test_memErrTelemetry;

  logic        clk = 1'b0;
  logic        porN, devReset;
  logic        sramEvtValid, sramEvtUncorr, dramEvtValid, dramEvtUncorr;
  logic [31:0] sramEvtAddr, dramEvtAddr;
  logic        timerTick;
  logic [15:0] windowTicks;
  logic        restoreValid;
  logic [63:0] restoreData, saveData;
  logic [3:0]  regAddr;
  logic [31:0] regRdData;
  logic        uncorrIrq, rateAlarm, retirePending, replaceDevice;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  bit  monBusy = 1'b0;

  always #4 clk = ~clk;

  memErrTelemetry i_memErrTelemetry (
    .clk(clk), .porN(porN), .devReset(devReset),
    .sramEvtValid(sramEvtValid), .sramEvtUncorr(sramEvtUncorr), .sramEvtAddr(sramEvtAddr),
    .dramEvtValid(dramEvtValid), .dramEvtUncorr(dramEvtUncorr), .dramEvtAddr(dramEvtAddr),
    .timerTick(timerTick), .windowTicks(windowTicks),
    .restoreValid(restoreValid), .restoreData(restoreData), .saveData(saveData),
    .regAddr(regAddr), .regRdData(regRdData),
    .uncorrIrq(uncorrIrq), .rateAlarm(rateAlarm),
    .retirePending(retirePending), .replaceDevice(replaceDevice)
  );

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] val;
    string       tag;
  } expT;

  expT sbQ[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver side: queue an expected register value
  task automatic expectReg(input logic [3:0] a, input logic [31:0] v, input string tag);
    expT e;
    e.addr = a;
    e.val  = v;
    e.tag  = tag;
    sbQ.push_back(e);
  endtask

  task automatic drain();
    while (sbQ.size() != 0 || monBusy) #1;
  endtask

  // monitor: pops expectations and compares against the read port
  initial begin
    regAddr = '0;
    forever begin
      #1;
      if (sbQ.size() != 0) begin
        expT e;
        monBusy = 1'b1;
        e = sbQ.pop_front();
        regAddr = e.addr;
        #1;
        chk($sformatf("%s idx%0d", e.tag, e.addr), {32'b0, regRdData}, {32'b0, e.val});
        monBusy = 1'b0;
      end
    end
  end

  task automatic evt(input bit sV, input bit sU, input logic [31:0] sA,
                     input bit dV, input bit dU, input logic [31:0] dA);
    @(negedge clk);
    sramEvtValid = sV; sramEvtUncorr = sU; sramEvtAddr = sA;
    dramEvtValid = dV; dramEvtUncorr = dU; dramEvtAddr = dA;
    @(posedge clk);
    @(negedge clk);
    sramEvtValid = 1'b0; dramEvtValid = 1'b0;
  endtask

  task automatic devPulse();
    @(negedge clk);
    devReset = 1'b1;
    @(negedge clk);
    devReset = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..R12 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit alarmSeen;
    porN = 1'b0; devReset = 1'b0;
    sramEvtValid = 1'b0; sramEvtUncorr = 1'b0; sramEvtAddr = '0;
    dramEvtValid = 1'b0; dramEvtUncorr = 1'b0; dramEvtAddr = '0;
    timerTick = 1'b0; windowTicks = 16'd1000;
    restoreValid = 1'b0; restoreData = '0;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);

    // R12 reset state
    for (int i = 0; i < 12; i++) expectReg(4'(i), 32'h0, "R12");
    drain();
    chk("R12 irq", {63'b0, uncorrIrq}, 64'd0);
    chk("R12 alarm", {63'b0, rateAlarm}, 64'd0);
    chk("R12 pending", {63'b0, retirePending}, 64'd0);
    chk("R12 replace", {63'b0, replaceDevice}, 64'd0);

    // R1 R2 basic counting
    repeat (3) evt(1, 0, 32'h40, 0, 0, 32'h0);
    evt(0, 0, 32'h0, 1, 0, 32'h0000_A000);
    expectReg(0, 3, "R1"); expectReg(2, 1, "R1");
    expectReg(4, 3, "R2"); expectReg(6, 1, "R2");
    drain();

    // R5 R8 R11 uncorrectable DRAM
    evt(0, 0, 32'h0, 1, 1, 32'h0000_5123);
    chk("R11 irq high", {63'b0, uncorrIrq}, 64'd1);
    chk("R8 pending", {63'b0, retirePending}, 64'd1);
    expectReg(10, 32'h5123, "R11"); expectReg(9, 1, "R5");
    expectReg(11, 1, "R5"); expectReg(3, 1, "R1"); expectReg(7, 1, "R2");
    drain();
    @(negedge clk);
    chk("R11 irq single", {63'b0, uncorrIrq}, 64'd0);

    // R7 repeat events on retired page 5
    evt(0, 0, 32'h0, 1, 1, 32'h0000_5FFF);
    evt(0, 0, 32'h0, 1, 0, 32'h0000_5000);
    evt(0, 0, 32'h0, 1, 0, 32'h0000_5004);
    expectReg(3, 2, "R7"); expectReg(11, 1, "R7");
    expectReg(9, 1, "R7"); expectReg(8, 0, "R7"); expectReg(2, 3, "R7");
    drain();

    // R6 two corrected hits on page 0x20
    evt(0, 0, 32'h0, 1, 0, 32'h0002_0010);
    expectReg(8, 0, "R6");
    drain();
    evt(0, 0, 32'h0, 1, 0, 32'h0002_0ABC);
    expectReg(8, 1, "R6"); expectReg(11, 2, "R6");
    drain();

    // R6 LRU eviction
    for (int p = 'h30; p <= 'h34; p++) evt(0, 0, 32'h0, 1, 0, 32'(p << 12));
    evt(0, 0, 32'h0, 1, 0, 32'h0003_0000);
    expectReg(8, 1, "R6 evicted"); expectReg(11, 2, "R6 evicted");
    drain();
    evt(0, 0, 32'h0, 1, 0, 32'h0003_4000);
    expectReg(8, 2, "R6 kept"); expectReg(11, 3, "R6 kept"); expectReg(2, 12, "R1");
    drain();

    // R3 R8 device reset
    devPulse();
    chk("R8 commit", {63'b0, retirePending}, 64'd0);
    for (int i = 0; i < 4; i++) expectReg(4'(i), 0, "R3");
    expectReg(4, 3, "R2"); expectReg(5, 0, "R2"); expectReg(6, 12, "R2"); expectReg(7, 2, "R2");
    expectReg(8, 2, "R12"); expectReg(9, 1, "R12"); expectReg(11, 3, "R12");
    expectReg(10, 32'h5FFF, "R12");
    drain();

    // R2 restore, R4 saturation
    @(negedge clk);
    restoreData = 64'h0009_0007_0005_FFFE;
    restoreValid = 1'b1;
    @(negedge clk);
    restoreValid = 1'b0;
    expectReg(4, 32'hFFFE, "R2"); expectReg(5, 5, "R2");
    drain();
    evt(1, 0, 32'h0, 0, 0, 32'h0);
    expectReg(4, 32'hFFFF, "R4");
    drain();
    evt(1, 0, 32'h0, 0, 0, 32'h0);
    expectReg(4, 32'hFFFF, "R4"); expectReg(0, 2, "R4");
    drain();
    chk("R2 save", saveData, 64'h0009_0007_0005_FFFF);

    // R10 short windows never accumulate past the limit
    windowTicks = 16'd50;
    timerTick = 1'b1;
    devPulse();
    alarmSeen = 1'b0;
    repeat (150) begin
      evt(1, 0, 32'h0, 0, 0, 32'h0);
      if (rateAlarm) alarmSeen = 1'b1;
    end
    chk("R10 window roll", {63'b0, alarmSeen}, 64'd0);

    // R10 threshold crossing inside one long window
    windowTicks = 16'd1000;
    devPulse();
    alarmSeen = 1'b0;
    repeat (100) begin
      evt(1, 0, 32'h0, 0, 0, 32'h0);
      if (rateAlarm) alarmSeen = 1'b1;
    end
    chk("R10 at limit", {63'b0, alarmSeen}, 64'd0);
    evt(1, 0, 32'h0, 0, 0, 32'h0);
    chk("R10 over limit", {63'b0, rateAlarm}, 64'd1);
    @(negedge clk);
    chk("R10 pulse", {63'b0, rateAlarm}, 64'd0);
    timerTick = 1'b0;

    // R9 retirement limit: 3 already, add 61 to reach 64
    for (int i = 0; i < 61; i++) evt(0, 0, 32'h0, 1, 1, 32'((256 + i) << 12));
    @(negedge clk);
    chk("R9 at limit", {63'b0, replaceDevice}, 64'd0);
    evt(0, 0, 32'h0, 1, 1, 32'h0080_0000);
    @(negedge clk);
    chk("R9 over limit", {63'b0, replaceDevice}, 64'd1);
    chk("R8 pending", {63'b0, retirePending}, 64'd1);
    expectReg(11, 65, "R5"); expectReg(9, 63, "R5");
    drain();

    // R12 power-on reset; R1 R9 R11 simultaneous uncorrectable events
    @(negedge clk);
    porN = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    chk("R12 replace cleared", {63'b0, replaceDevice}, 64'd0);
    expectReg(11, 0, "R12"); expectReg(10, 0, "R12");
    drain();
    evt(1, 1, 32'h0000_7777, 1, 1, 32'h0000_9000);
    chk("R11 irq both", {63'b0, uncorrIrq}, 64'd1);
    chk("R9 sram ue", {63'b0, replaceDevice}, 64'd1);
    expectReg(1, 1, "R1"); expectReg(3, 1, "R1");
    expectReg(5, 1, "R1"); expectReg(7, 1, "R1");
    expectReg(10, 32'h9000, "R11"); expectReg(11, 1, "R5");
    drain();
    evt(1, 1, 32'h0000_7777, 0, 0, 32'h0);
    expectReg(10, 32'h7777, "R11"); expectReg(1, 2, "R1");
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule